// File: doc/BRIEF.md
# Programmable PPS pulse generator

This block produces a square wave on one output pin, locked to a running time-of-day value made of a whole-nanosecond count and a 32-bit binary fraction. The usual setting is one pulse per second. The block holds a next-edge threshold and compares it with the incoming time on every clock. When the time reaches or passes the threshold, the output level flips. The threshold then moves forward by the duration of the phase that has just begun. Each phase has its own duration, in nanoseconds with a 32-bit fraction. The duty cycle can therefore be symmetric or asymmetric, and the period can be longer than one rollover of the nanosecond count.

Software programs the block through a simple write port: a control word, the threshold and the two phase durations. The nanosecond count of the time input wraps to zero at a rollover value, which is a parameter and is one second by default. The block treats that wrap as continuous time. A threshold that lies beyond the current rollover interval is carried forward by subtracting the rollover value at each wrap.

Top module: `pps_pulse_gen`

## Requirements
- R1: After reset the control word is cleared (enable 0, invert 0), and `pps_out` is 0.
- R2: While the enable bit (control word bit 30) is 0, `pps_out` equals the invert bit (control word bit 31), and time never makes it toggle.
- R3: When enabled, `pps_out` first toggles into the active (high) phase one clock after the first time sample whose value is at or past the threshold.
- R4: After a toggle into the high phase, the next toggle comes at the previous threshold plus the high-phase duration. After a toggle into the low phase, it comes at the previous threshold plus the low-phase duration. The two durations may differ.
- R5: Durations and the threshold are fixed point: whole nanoseconds in one word and a fraction in units of 2^-32 ns in another. An edge falls on the first time sample that is at or past the fractional threshold.
- R6: A wrap of `tod_ns` from the rollover value minus one back to 0 is treated as continuous time, so edge spacing is exact across the wrap.
- R7: A phase duration longer than the rollover value is honoured: edges stay the programmed duration apart in absolute time.
- R8: While enabled, the invert bit XORs the output level, so the first edge after enabling is a falling edge.
- R9: Clearing the enable bit returns `pps_out` to the invert level on the next clock and resets the phase, so the next enable starts again with the high phase.
- R10: Write address map on `wr_addr`: 0 control, 1 threshold whole ns, 2 threshold fraction, 3 high duration whole ns, 4 high duration fraction, 5 low duration whole ns, 6 low duration fraction. A write to address 7 has no effect.
- R11: `pps_out` changes only one clock after a threshold hit or after a control word write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tod_ns | input | WORD_W | Time of day, whole nanoseconds, wraps at ROLL_NS |
| tod_frac | input | WORD_W | Time of day, nanosecond fraction in 2^-32 ns |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select (see R10) |
| wr_data | input | WORD_W | Register write data |
| pps_out | output | 1 | Pulse output |

## Verification
Several rules are checked on every cycle. While disabled, the output must sit at the invert level. Any output change must trace back to a threshold hit or a control write. The phase must be clear when enable rises and one cycle after it falls. Edge placement needs a time model, so only the bench scenarios can show it: a scoreboard predicts each edge time and level for symmetric, asymmetric, fractional and multi-rollover durations, including edges on both sides of the nanosecond wrap. The bench also covers the invert and disable sequences and the unused address.

// File: rtl/pps_pkg.sv
`timescale 1ns/1ps
package pps_pkg;
  localparam int ADDR_W       = 3;
  localparam int CTRL_EN_BIT  = 30;
  localparam int CTRL_INV_BIT = 31;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 3'd0,
    REG_THR_NS = 3'd1,
    REG_THR_FR = 3'd2,
    REG_HI_NS  = 3'd3,
    REG_HI_FR  = 3'd4,
    REG_LO_NS  = 3'd5,
    REG_LO_FR  = 3'd6
  } pps_reg_e;
endpackage

// File: rtl/pps_rst_sync.sv
`timescale 1ns/1ps
module pps_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/pps_regs.sv
`timescale 1ns/1ps
module pps_regs import pps_pkg::*; #(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [W-1:0]      wr_data_i,
  output logic              en_o,
  output logic              inv_o,
  output logic [2*W-1:0]    hi_step_o,
  output logic [2*W-1:0]    lo_step_o,
  output logic              thr_ns_we_o,
  output logic              thr_fr_we_o
);
  localparam int SW = 2 * W;

  logic en_q, en_d, inv_q, inv_d;
  logic ctrl_we;
  logic [1:0][SW-1:0] step_q;

  assign ctrl_we     = wr_en_i && (wr_addr_i == REG_CTRL);
  assign thr_ns_we_o = wr_en_i && (wr_addr_i == REG_THR_NS);
  assign thr_fr_we_o = wr_en_i && (wr_addr_i == REG_THR_FR);

  always_comb begin
    en_d  = en_q;
    inv_d = inv_q;
    if (ctrl_we) begin
      en_d  = wr_data_i[CTRL_EN_BIT];
      inv_d = wr_data_i[CTRL_INV_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      inv_q <= 1'b0;
    end else if (ctrl_we) begin
      en_q  <= en_d;
      inv_q <= inv_d;
    end
  end

  // index 1: high-phase duration, index 0: low-phase duration
  for (genvar p = 0; p < 2; p++) begin : g_step
    localparam pps_reg_e NS_A = (p == 1) ? REG_HI_NS : REG_LO_NS;
    localparam pps_reg_e FR_A = (p == 1) ? REG_HI_FR : REG_LO_FR;
    logic          ns_we, fr_we;
    logic [SW-1:0] step_r, step_d;

    assign ns_we = wr_en_i && (wr_addr_i == NS_A);
    assign fr_we = wr_en_i && (wr_addr_i == FR_A);

    always_comb begin
      step_d = step_r;
      if (ns_we) step_d[SW-1:W] = wr_data_i;
      if (fr_we) step_d[W-1:0]  = wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              step_r <= '0;
      else if (ns_we || fr_we) step_r <= step_d;
    end

    assign step_q[p] = step_r;
  end

  assign en_o      = en_q;
  assign inv_o     = inv_q;
  assign hi_step_o = step_q[1];
  assign lo_step_o = step_q[0];
endmodule

// File: rtl/pps_thr_track.sv
`timescale 1ns/1ps
module pps_thr_track #(
  parameter int              W       = 32,
  parameter longint unsigned ROLL_NS = 64'd1_000_000_000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_i,
  input  logic [W-1:0]   tod_ns_i,
  input  logic [W-1:0]   tod_fr_i,
  input  logic           thr_ns_we_i,
  input  logic           thr_fr_we_i,
  input  logic [W-1:0]   wdata_i,
  input  logic [2*W-1:0] hi_step_i,
  input  logic [2*W-1:0] lo_step_i,
  output logic           phase_o,
  output logic           hit_o
);
  localparam int TW = W + 2;          // whole part, room for a threshold beyond one rollover
  localparam int AW = TW + W;         // fixed-point threshold width
  localparam logic [TW-1:0] ROLL_W  = TW'(ROLL_NS);
  localparam logic [AW-1:0] ROLL_FX = {ROLL_W, {W{1'b0}}};

  logic [W-1:0]   prev_ns_q;
  logic [AW-1:0]  thr_q, thr_d, adv, now_fx;
  logic [2*W-1:0] step;
  logic           phase_q, phase_d, wrap, hit;

  assign wrap   = tod_ns_i < prev_ns_q;
  assign now_fx = {({2'b00, tod_ns_i} + (wrap ? ROLL_W : '0)), tod_fr_i};
  assign hit    = en_i && (now_fx >= thr_q);
  // the phase about to be entered picks the increment
  assign step   = phase_q ? lo_step_i : hi_step_i;
  assign adv    = thr_q + (hit ? {2'b00, step} : '0);

  always_comb begin
    thr_d   = thr_q;
    phase_d = phase_q;
    if (!en_i) begin
      phase_d = 1'b0;
    end else begin
      if (hit) phase_d = ~phase_q;
      if (wrap) thr_d = (adv >= ROLL_FX) ? (adv - ROLL_FX) : '0;
      else      thr_d = adv;
    end
    if (thr_ns_we_i) thr_d[AW-1:W] = {2'b00, wdata_i};
    if (thr_fr_we_i) thr_d[W-1:0]  = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_ns_q <= '0;
      thr_q     <= '0;
      phase_q   <= 1'b0;
    end else begin
      prev_ns_q <= tod_ns_i;
      thr_q     <= thr_d;
      phase_q   <= phase_d;
    end
  end

  assign phase_o = phase_q;
  assign hit_o   = hit;
endmodule

// File: rtl/pps_pulse_gen.sv
`timescale 1ns/1ps
module pps_pulse_gen import pps_pkg::*; #(
  parameter int              WORD_W  = 32,
  parameter longint unsigned ROLL_NS = 64'd1_000_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] tod_ns,
  input  logic [WORD_W-1:0] tod_frac,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic              pps_out
);
  logic                rst_n_s;
  logic                ctrl_en, ctrl_inv;
  logic [2*WORD_W-1:0] hi_step, lo_step;
  logic                thr_ns_we, thr_fr_we;
  logic                phase, hit;

  pps_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_s)
  );

  pps_regs #(.W(WORD_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .en_o        (ctrl_en),
    .inv_o       (ctrl_inv),
    .hi_step_o   (hi_step),
    .lo_step_o   (lo_step),
    .thr_ns_we_o (thr_ns_we),
    .thr_fr_we_o (thr_fr_we)
  );

  pps_thr_track #(.W(WORD_W), .ROLL_NS(ROLL_NS)) u_track (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .en_i        (ctrl_en),
    .tod_ns_i    (tod_ns),
    .tod_fr_i    (tod_frac),
    .thr_ns_we_i (thr_ns_we),
    .thr_fr_we_i (thr_fr_we),
    .wdata_i     (wr_data),
    .hi_step_i   (hi_step),
    .lo_step_i   (lo_step),
    .phase_o     (phase),
    .hit_o       (hit)
  );

  assign pps_out = ctrl_en ? (phase ^ ctrl_inv) : ctrl_inv;
endmodule

// File: rtl/pps_pulse_gen_chk.sv
`timescale 1ns/1ps
module pps_pulse_gen_chk import pps_pkg::*; (
  input logic              clk,
  input logic              rst_n,
  input logic              pps_out,
  input logic              cfg_en,
  input logic              cfg_inv,
  input logic              phase,
  input logic              hit,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr
);
  logic cfg_wr;
  assign cfg_wr = wr_en && (wr_addr == REG_CTRL);

  assert_idle_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |-> (pps_out == cfg_inv));

  assert_edge_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pps_out) |-> ($past(hit) || $past(cfg_wr)));

  assert_start_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_en) |-> !phase);

  assert_phase_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_en) |=> !phase);
endmodule

bind pps_pulse_gen pps_pulse_gen_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n_s),
  .pps_out (pps_out),
  .cfg_en  (ctrl_en),
  .cfg_inv (ctrl_inv),
  .phase   (phase),
  .hit     (hit),
  .wr_en   (wr_en),
  .wr_addr (wr_addr)
);

// File: tb/sim_pps_pulse_gen.sv
`timescale 1ns/1ps
module sim_pps_pulse_gen;
  localparam int     W    = 32;
  localparam longint ROLL = 1000;

  typedef struct { longint t; bit lvl; } exp_t;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] tod_ns, tod_frac;
  logic         wr_en;
  logic [2:0]   wr_addr;
  logic [W-1:0] wr_data;
  logic         pps_out;

  exp_t   sb[$];
  longint abs_ns;
  int     checks = 0, fails = 0;
  bit     mon_on = 1'b0;
  logic   last_out;

  always #2.5 clk = ~clk;

  pps_pulse_gen #(.WORD_W(W), .ROLL_NS(ROLL)) u0 (
    .clk(clk), .rst_n(rst_n), .tod_ns(tod_ns), .tod_frac(tod_frac),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .pps_out(pps_out)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // time model and scoreboard monitor: one process, evaluated at negedge
  initial begin
    abs_ns = 0; tod_ns = '0; tod_frac = '0; last_out = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && mon_on && (pps_out !== last_out)) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R11", "unexpected edge at time", abs_ns, -1);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(abs_ns == e.t, "R4", "edge time", abs_ns, e.t);
          chk(pps_out == e.lvl, "R8", "edge level", longint'(pps_out), longint'(e.lvl));
        end
      end
      last_out = pps_out;
      abs_ns++;
      tod_ns = W'(abs_ns % ROLL);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // durations and fraction in quarter nanoseconds; n expected edges
  task automatic run_pulses(string req, int want_mod, longint hi_ns, int hi_q,
                            longint lo_ns, int lo_q, int thr_q, bit inv, int n);
    longint a, rel, thr4, hi4, lo4, last_t;
    @(negedge clk);
    if (want_mod >= 0)
      while ((abs_ns % ROLL) < want_mod || (abs_ns % ROLL) > want_mod + 50) @(negedge clk);
    else
      while ((abs_ns % ROLL) > ROLL - 60) @(negedge clk);
    a    = abs_ns;
    rel  = (a % ROLL) + 40;
    thr4 = (a - (a % ROLL) + rel) * 4 + thr_q;
    hi4  = hi_ns * 4 + hi_q;
    lo4  = lo_ns * 4 + lo_q;
    wr(3'd3, W'(hi_ns));
    wr(3'd4, W'(hi_q) << 30);
    wr(3'd5, W'(lo_ns));
    wr(3'd6, W'(lo_q) << 30);
    wr(3'd1, W'(rel));
    wr(3'd2, W'(thr_q) << 30);
    last_t = 0;
    for (int k = 0; k < n; k++) begin
      exp_t e;
      e.t = (thr4 + 3) / 4;
      e.lvl = inv ^ (k % 2 == 0);
      sb.push_back(e);
      last_t = e.t;
      thr4 += (k % 2 == 0) ? hi4 : lo4;
    end
    mon_on = 1'b1;
    wr(3'd0, {inv, 1'b1, 30'b0});
    while (sb.size() > 0 && abs_ns < last_t + 10) @(negedge clk);
    chk(sb.size() == 0, req, "edges missing", longint'(sb.size()), 0);
    sb.delete();
    mon_on = 1'b0;
    wr(3'd0, {inv, 1'b0, 30'b0});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(pps_out == 1'b0, "R1", "reset level", longint'(pps_out), 0);

    // R10: address 7 aliases nothing
    wr(3'd7, 32'hFFFF_FFFF);
    repeat (3) @(negedge clk);
    chk(pps_out == 1'b0, "R10", "write to address 7", longint'(pps_out), 0);

    // R2: disabled with invert, time runs past a zero threshold
    wr(3'd0, 32'h8000_0000);
    mon_on = 1'b1;
    repeat (300) @(negedge clk);
    chk(pps_out == 1'b1, "R2", "idle inverted level", longint'(pps_out), 1);
    mon_on = 1'b0;
    wr(3'd0, 32'h0);
    chk(pps_out == 1'b0, "R2", "idle level", longint'(pps_out), 0);

    run_pulses("R3", -1, 100, 0, 100, 0, 0, 1'b0, 6);   // symmetric
    run_pulses("R6", 600, 30, 0, 170, 0, 0, 1'b0, 6);   // asymmetric, across wrap
    run_pulses("R7", -1, 1250, 0, 1250, 0, 0, 1'b0, 4); // phases longer than rollover
    run_pulses("R5", -1, 100, 2, 100, 2, 1, 1'b0, 4);   // fractional 100.5 / 0.25

    // R8: inverted output
    wr(3'd0, 32'h8000_0000);
    run_pulses("R8", -1, 50, 0, 80, 0, 0, 1'b1, 4);
    wr(3'd0, 32'h0);

    // R9: disable during high phase, then re-enable starts high
    run_pulses("R9", -1, 300, 0, 300, 0, 0, 1'b0, 1);
    chk(pps_out == 1'b0, "R9", "level after disable", longint'(pps_out), 0);
    run_pulses("R9", -1, 60, 0, 90, 0, 0, 1'b0, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule